// File: doc/BRIEF.md
# Outbound Address Window Translator

This block turns a CPU-side request, given as a window index plus an offset inside that window, into a 64-bit PCIe address. It holds four windows. Software programs each one through a small write port. A window has a 64-bit PCIe base, a size field and a control word. The control word carries an enable flag and a flag that selects I/O space instead of memory space.

When a request arrives, the block checks the addressed window. If the window is enabled and the offset lies inside its span, the result is a hit carrying the base plus the offset and the space type. If the window is disabled or the offset reaches past the span, the result is a miss with a zero address. The result appears one clock cycle after the request.

To reprogram a window, software first clears its control word, which turns the window off. It then rewrites the base and the size, and writes the control word last to turn the window back on.

Top module: `obwin_xlate`

## Requirements
- R1: After reset, rsp_valid is low and every window is disabled, so a request to any window yields a miss.
- R2: A request presented with req_valid high in one cycle produces rsp_valid high, with its result, on the next rising clock edge. No other latency is allowed.
- R3: A hit returns rsp_addr equal to the 64-bit base of the window plus the zero-extended offset, with rsp_hit high and rsp_miss low.
- R4: The window span covers the offset bits set in {size_field, 7'h7F}. Offset bits 6:0 are always inside the span. An offset with any bit set above the span gives a miss.
- R5: A window whose control bit 31 is clear gives a miss with rsp_addr zero and rsp_io low. Clearing the control word therefore disables a window while it is being reprogrammed.
- R6: On a hit, rsp_io equals bit 8 of the window's control word (1 = I/O space, 0 = memory space).
- R7: Each window keeps its own registers. req_win picks which window's registers translate the request.
- R8: Register select codes on cfg_sel are 0 = base bits 31:0, 1 = base bits 63:32, 2 = size (data bits 31:7, counted in 128-byte units minus one), 3 = control. The 64-bit addition carries from the low half into the high half.
- R9: Bits 6:0 of the size register write are ignored and do not change the span.
- R10: When rsp_valid is high, exactly one of rsp_hit and rsp_miss is high. When rsp_valid is low, both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | 2 | Window targeted by the write |
| cfg_sel | input | 2 | Register select (see R8) |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation request strobe |
| req_win | input | 2 | Window index of the request |
| req_offset | input | 32 | Offset within the window |
| rsp_valid | output | 1 | Result valid, one cycle after req_valid |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Window disabled or offset out of range |
| rsp_io | output | 1 | 1 = I/O space, 0 = memory space |
| rsp_addr | output | 64 | Translated PCIe address (zero on a miss) |

## Verification
Every result is due exactly one rising edge after its request. Register writes take effect at the edge that samples them.

The bench drives inputs on the falling edge. It samples the response on the next falling edge, half a cycle after the edge that registers it. Back-to-back requests are checked the same way, so each sample belongs to the request driven one cycle earlier.

Reprogramming runs one write per cycle. Requests are only issued after the last write has settled.

// File: rtl/obw_pkg.sv
package obw_pkg;
  parameter int CFG_W    = 32;
  parameter int GRAN_LSB = 7;   // 128-byte granularity
  parameter int ADDR_W   = 2 * CFG_W;
  parameter int SIZE_W   = CFG_W - GRAN_LSB;

  typedef enum logic [1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_SIZE    = 2'd2,
    SEL_CTRL    = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT = 31;
  localparam int CTRL_IO_BIT = 8;

  // Offset bits covered by a window of the given size field.
  function automatic logic [CFG_W-1:0] span_of(input logic [SIZE_W-1:0] fld);
    return {fld, {GRAN_LSB{1'b1}}};
  endfunction

  // True when the offset reaches past the span.
  function automatic logic beyond_span(input logic [CFG_W-1:0] off,
                                       input logic [SIZE_W-1:0] fld);
    return |(off & ~span_of(fld));
  endfunction

  function automatic logic [ADDR_W-1:0] xlate(input logic [ADDR_W-1:0] base,
                                               input logic [CFG_W-1:0] off);
    return base + {{(ADDR_W-CFG_W){1'b0}}, off};
  endfunction
endpackage

// File: rtl/obw_regfile.sv
module obw_regfile
  import obw_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int WIN_W = $clog2(NWIN)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [WIN_W-1:0]              cfg_win,
  input  logic [1:0]                    cfg_sel,
  input  logic [CFG_W-1:0]              cfg_wdata,
  output logic [NWIN-1:0][ADDR_W-1:0]   base_o,
  output logic [NWIN-1:0][SIZE_W-1:0]   size_o,
  output logic [NWIN-1:0]               en_o,
  output logic [NWIN-1:0]               io_o
);
  logic [NWIN-1:0] win_wr;

  for (genvar w = 0; w < NWIN; w++) begin : g_dec
    assign win_wr[w] = cfg_we && (cfg_win == WIN_W'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o <= '0;
      size_o <= '0;
      en_o   <= '0;
      io_o   <= '0;
    end else begin
      for (int w = 0; w < NWIN; w++) begin
        if (win_wr[w]) begin
          unique case (reg_sel_e'(cfg_sel))
            SEL_BASE_LO: base_o[w][CFG_W-1:0]      <= cfg_wdata;
            SEL_BASE_HI: base_o[w][ADDR_W-1:CFG_W] <= cfg_wdata;
            SEL_SIZE:    size_o[w]                 <= cfg_wdata[CFG_W-1:GRAN_LSB];
            SEL_CTRL: begin
              en_o[w] <= cfg_wdata[CTRL_EN_BIT];
              io_o[w] <= cfg_wdata[CTRL_IO_BIT];
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R8: low base write lands in the addressed window
  assert_base_low_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd0) |=> base_o[$past(cfg_win)][CFG_W-1:0] == $past(cfg_wdata));

  // R5: clearing the control word disables the window
  assert_ctrl_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3 && !cfg_wdata[CTRL_EN_BIT]) |=> !en_o[$past(cfg_win)]);
endmodule

// File: rtl/obw_lookup.sv
module obw_lookup
  import obw_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int WIN_W = $clog2(NWIN)
) (
  input  logic [NWIN-1:0][ADDR_W-1:0] base_i,
  input  logic [NWIN-1:0][SIZE_W-1:0] size_i,
  input  logic [NWIN-1:0]             en_i,
  input  logic [NWIN-1:0]             io_i,
  input  logic [WIN_W-1:0]            win_i,
  input  logic [CFG_W-1:0]            off_i,
  output logic                        sel_en_o,
  output logic                        over_range_o,
  output logic                        hit_o,
  output logic                        io_o,
  output logic [ADDR_W-1:0]           addr_o
);
  logic [ADDR_W-1:0] sel_base;
  logic [SIZE_W-1:0] sel_size;

  always_comb begin
    sel_base     = base_i[win_i];
    sel_size     = size_i[win_i];
    sel_en_o     = en_i[win_i];
    over_range_o = beyond_span(off_i, sel_size);
    hit_o        = sel_en_o && !over_range_o;
    io_o         = hit_o && io_i[win_i];
    addr_o       = hit_o ? xlate(sel_base, off_i) : '0;
  end
endmodule

// File: rtl/obwin_xlate.sv
module obwin_xlate
  import obw_pkg::*;
#(
  parameter int NWIN  = 4,
  parameter int WIN_W = $clog2(NWIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WIN_W-1:0]  cfg_win,
  input  logic [1:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req_valid,
  input  logic [WIN_W-1:0]  req_win,
  input  logic [CFG_W-1:0]  req_offset,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_io,
  output logic [ADDR_W-1:0] rsp_addr
);
  logic [NWIN-1:0][ADDR_W-1:0] base_w;
  logic [NWIN-1:0][SIZE_W-1:0] size_w;
  logic [NWIN-1:0]             en_w;
  logic [NWIN-1:0]             io_w;
  logic                        sel_en;
  logic                        over_range;
  logic                        lk_hit;
  logic                        lk_io;
  logic [ADDR_W-1:0]           lk_addr;

  obw_regfile #(.NWIN(NWIN), .WIN_W(WIN_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .base_o(base_w), .size_o(size_w), .en_o(en_w), .io_o(io_w)
  );

  obw_lookup #(.NWIN(NWIN), .WIN_W(WIN_W)) i_lookup (
    .base_i(base_w), .size_i(size_w), .en_i(en_w), .io_i(io_w),
    .win_i(req_win), .off_i(req_offset),
    .sel_en_o(sel_en), .over_range_o(over_range),
    .hit_o(lk_hit), .io_o(lk_io), .addr_o(lk_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_io    <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && lk_hit;
      rsp_miss  <= req_valid && !lk_hit;
      rsp_io    <= req_valid && lk_io;
      rsp_addr  <= req_valid ? lk_addr : '0;
    end
  end

  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss));

  assert_hit_miss_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss}));

  assert_disabled_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sel_en) |=> (rsp_miss && rsp_addr == '0 && !rsp_io));

  assert_over_range_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && over_range) |=> rsp_miss);
endmodule

// File: tb/test_obwin_xlate.sv
module test_obwin_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_win = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_win = '0;
  logic [31:0] req_offset = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_io;
  logic [63:0] rsp_addr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  obwin_xlate i_obwin_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_win(req_win), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_io(rsp_io), .rsp_addr(rsp_addr)
  );

  // vector: {win[1:0], offset[31:0], hit, io, addr[63:0]}
  localparam int NVEC = 10;
  localparam logic [99:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_0000, 1'b1, 1'b0, 64'h0000_0001_0000_0000},  // R3 R7
    {2'd0, 32'h0000_0FFF, 1'b1, 1'b0, 64'h0000_0001_0000_0FFF},  // R4 top of span
    {2'd0, 32'h0000_1000, 1'b0, 1'b0, 64'h0},                    // R4 beyond
    {2'd1, 32'h0000_1234, 1'b1, 1'b1, 64'h0000_0001_0000_0234},  // R8 carry, R6 io
    {2'd1, 32'h0000_FFFF, 1'b1, 1'b1, 64'h0000_0001_0000_EFFF},  // R8 R6
    {2'd1, 32'h0001_0000, 1'b0, 1'b0, 64'h0},                    // R4
    {2'd2, 32'h0000_007F, 1'b1, 1'b0, 64'h1234_5678_0000_007F},  // R9 R4 low bits
    {2'd2, 32'h0000_0080, 1'b0, 1'b0, 64'h0},                    // R9
    {2'd3, 32'h0000_0000, 1'b0, 1'b0, 64'h0},                    // R5 disabled
    {2'd0, 32'h8000_0000, 1'b0, 1'b0, 64'h0}                     // R4 top bit
  };

  task automatic check(input string req, input logic [67:0] act, input logic [67:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_win = w; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive at negedge, result due one edge later, sampled at the next negedge
  task automatic do_req(input logic [1:0] w, input logic [31:0] off);
    req_valid = 1'b1; req_win = w; req_offset = off;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [67:0] rsp_pack();
    return {rsp_valid, rsp_hit, rsp_miss, rsp_io, rsp_addr};
  endfunction

  initial begin
    #400_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", rsp_pack(), 68'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(2'd0, 32'h0);
    check("R1 miss after reset", rsp_pack(), {4'b1010, 64'h0});

    // program windows, control last
    wr(2'd0, 2'd0, 32'h0000_0000); wr(2'd0, 2'd1, 32'h0000_0001);
    wr(2'd0, 2'd2, 32'h0000_0F80); wr(2'd0, 2'd3, 32'h8000_0000);
    wr(2'd1, 2'd0, 32'hFFFF_F000); wr(2'd1, 2'd1, 32'h0000_0000);
    wr(2'd1, 2'd2, 32'h0000_FF80); wr(2'd1, 2'd3, 32'h8000_0100);
    wr(2'd2, 2'd0, 32'h0000_0000); wr(2'd2, 2'd1, 32'h1234_5678);
    wr(2'd2, 2'd2, 32'h0000_007F); wr(2'd2, 2'd3, 32'h8000_0000);
    wr(2'd3, 2'd0, 32'h0000_0000); wr(2'd3, 2'd2, 32'hFFFF_FF80);
    wr(2'd3, 2'd3, 32'h0000_0100);

    for (int i = 0; i < NVEC; i++) begin
      logic [99:0] v;
      v = VEC[i];
      do_req(v[99:98], v[97:66]);
      check($sformatf("R3 R4 R6 vector %0d", i), rsp_pack(),
            {1'b1, v[65], ~v[65], v[64], v[63:0]});
    end

    // R10 R2: idle cycle gives no response
    @(negedge clk);
    check("R10 idle", rsp_pack(), 68'h0);

    // R2: back-to-back requests, each due one cycle later
    req_valid = 1'b1; req_win = 2'd0; req_offset = 32'h10;
    @(negedge clk);
    check("R2 first", rsp_pack(), {4'b1100, 64'h0000_0001_0000_0010});
    req_win = 2'd1; req_offset = 32'h20;
    @(negedge clk);
    check("R2 second", rsp_pack(), {4'b1101, 64'h0000_0000_FFFF_F020});
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 drop", rsp_pack(), 68'h0);

    // R5: clearing control disables during reprogramming
    wr(2'd0, 2'd3, 32'h0000_0000);
    do_req(2'd0, 32'h0);
    check("R5 cleared ctrl", rsp_pack(), {4'b1010, 64'h0});
    wr(2'd0, 2'd0, 32'h0000_4000);
    wr(2'd0, 2'd3, 32'h8000_0000);
    do_req(2'd0, 32'h4);
    check("R8 reenabled", rsp_pack(), {4'b1100, 64'h0000_0001_0000_4004});
    // R7: window 1 untouched by window 0 reprogramming
    do_req(2'd1, 32'h0);
    check("R7 independent", rsp_pack(), {4'b1101, 64'h0000_0000_FFFF_F000});

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule